// File: doc/BRIEF.md
# Two-Wire Bus Target Address Decoder

This block is the receive-side front end of a target on an oversampled two-wire serial bus (I2C style: one clock line, one data line, open-drain with pull-ups). Both lines are brought into the system clock domain through a synchronizer chain, and every bus event is derived from the synchronized samples. These events are clock edges, START, repeated START and STOP. The block shifts in the address phase and decides whether the transfer is meant for this device. When it is, the block acknowledges by pulling the data line low. It then hands each received data byte to a byte-wide output with a one-cycle strobe, or, for a read, shifts out a byte supplied by the surrounding logic.

A configuration input selects either a 7-bit own address or a 10-bit own address. The all-zero write address is a broadcast that is always accepted. In 10-bit mode the block decodes the two-byte address form. It also remembers a completed 10-bit write selection, so that a repeated START followed by only the prefix byte with the read flag selects the device again. The block never holds the clock line low.

Top module: `i2c_tgt_addr_dec`

## Requirements
- R1: A START (data falling while clock is high) or STOP (data rising while clock is high) is recognised in any state and aborts the byte in progress. After a STOP, `selected_o` is 0 and the data line is released.
- R2: Bits are sampled on the rising clock edge and assembled most significant bit first.
- R3: With `mode10_i`=0, the first byte after a START is {addr[6:0], rw}. The block acknowledges only when addr equals `own_addr_i[6:0]`, and then raises `selected_o` and sets `dir_read_o` to rw (1 means read).
- R4: A first byte of 0x00 is acknowledged in both modes, with `selected_o`=1, `gcall_o`=1 and `dir_read_o`=0.
- R5: With `mode10_i`=1, a first byte of 0b11110 followed by `own_addr_i[9:8]` and rw=0 is acknowledged. The next byte is acknowledged, and `selected_o` raised, only when it equals `own_addr_i[7:0]`. Any other prefix is not acknowledged.
- R6: With `mode10_i`=1, the prefix byte with rw=1 is acknowledged, and selects the device for reading, only if a complete 10-bit write match has happened since the last STOP.
- R7: The acknowledge pull is applied only during the ninth clock. It starts after the clock falls at the end of the eighth bit and is released after the ninth clock falls.
- R8: While the device is selected for writing, every data byte is acknowledged and appears on `rx_data_o` with `rx_valid_o` high for exactly one cycle.
- R9: When the address does not match, the block does not pull the data line and produces no `rx_valid_o` until the next START or STOP.
- R10: A repeated START without a STOP restarts address decoding. A mismatching address after it deselects the device, and a matching one selects it.
- R11: When selected for reading, the block shifts out `tx_byte_i` MSB first, pulling the line for 0 bits. It reloads `tx_byte_i` after each master acknowledge and releases the line for good after a master not-acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| mode10_i | input | 1 | 1 selects the 10-bit own address |
| own_addr_i | input | 10 | Own address; bits 6:0 in 7-bit mode |
| tx_byte_i | input | 8 | Byte returned to the master on a read |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| selected_o | output | 1 | Device addressed in the current transfer |
| dir_read_o | output | 1 | 1 when the master reads from the device |
| gcall_o | output | 1 | Current selection came from the broadcast address |

## Verification
The assertions assume that each bus level is held for longer than the synchronizer latency. They also assume that the data line changes only while the clock is low, except during START and STOP. Under those conditions, a change of the pull output can follow only a synchronized clock fall or a bus condition. The stimulus drives every phase of the bus for five system clocks, and it moves the data line only a quarter period after a clock fall. This leaves room for the two-stage synchronizer and the response register. The open-drain bus is modelled as the AND of the master's data level and the target's released line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int DATA_BITS = 8;
    localparam int CNT_W     = $clog2(DATA_BITS + 2);
    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_RX,
        ST_TX
    } tgt_st_e;

    typedef struct packed {
        tgt_st_e              st;
        tgt_st_e              nx;
        logic [CNT_W-1:0]     cnt;
        logic [DATA_BITS-1:0] sh;
        logic                 drv;
        logic                 sel;
        logic                 rd;
        logic                 gc;
        logic                 hi_ok;
        logic                 nack;
        logic [DATA_BITS-1:0] rx;
        logic                 rxv;
    } tgt_reg_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN-1:0] scl_ff_d, scl_ff_q, sda_ff_d, sda_ff_q;
    logic             scl_p_d, scl_p_q, sda_p_d, sda_p_q;
    logic             scl_s, sda_s;

    assign scl_s = scl_ff_q[CHAIN-1];
    assign sda_s = sda_ff_q[CHAIN-1];

    always_comb begin
        scl_ff_d = {scl_ff_q[CHAIN-2:0], scl_i};
        sda_ff_d = {sda_ff_q[CHAIN-2:0], sda_i};
        scl_p_d  = scl_s;
        sda_p_d  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q <= '1;
            sda_ff_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_ff_q <= scl_ff_d;
            sda_ff_q <= sda_ff_d;
            scl_p_q  <= scl_p_d;
            sda_p_q  <= sda_p_d;
        end
    end

    assign sda_s_o = sda_s;
    assign rise_o  = scl_s & ~scl_p_q;
    assign fall_o  = ~scl_s & scl_p_q;
    assign start_o = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_o  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
    import i2c_tgt_pkg::*;
#(
    parameter bit GCALL_EN = 1'b1
) (
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic [9:0]           own_i,
    output logic                 hit7_o,
    output logic                 gc_o,
    output logic                 pfx_o,
    output logic                 lo_o
);
    assign hit7_o = (byte_i[7:1] == own_i[6:0]);
    assign pfx_o  = (byte_i[7:3] == TEN_BIT_TAG) && (byte_i[2:1] == own_i[9:8]);
    assign lo_o   = (byte_i == own_i[7:0]);

    generate
        if (GCALL_EN) begin : g_gcall
            assign gc_o = (byte_i == '0);
        end else begin : g_no_gcall
            assign gc_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/i2c_tgt_addr_dec.sv
module i2c_tgt_addr_dec
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit GCALL_EN    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic                 mode10_i,
    input  logic [9:0]           own_addr_i,
    input  logic [DATA_BITS-1:0] tx_byte_i,
    output logic                 sda_pull_o,
    output logic [DATA_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o,
    output logic                 selected_o,
    output logic                 dir_read_o,
    output logic                 gcall_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(DATA_BITS + 1);
    localparam tgt_reg_t REG_RST = '{
        st: ST_IDLE, nx: ST_IDLE, cnt: '0, sh: '0, drv: 1'b0, sel: 1'b0,
        rd: 1'b0, gc: 1'b0, hi_ok: 1'b0, nack: 1'b0, rx: '0, rxv: 1'b0
    };

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic hit7, gc_hit, pfx_hit, lo_hit;
    tgt_reg_t r_d, r_q;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_s_o (sda_s),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall),
        .start_o (bus_start),
        .stop_o  (bus_stop)
    );

    i2c_tgt_match #(.GCALL_EN(GCALL_EN)) u_match (
        .byte_i (r_q.sh),
        .own_i  (own_addr_i),
        .hit7_o (hit7),
        .gc_o   (gc_hit),
        .pfx_o  (pfx_hit),
        .lo_o   (lo_hit)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rxv = 1'b0;
        if (bus_stop) begin
            r_d.st    = ST_IDLE;
            r_d.cnt   = '0;
            r_d.drv   = 1'b0;
            r_d.sel   = 1'b0;
            r_d.rd    = 1'b0;
            r_d.gc    = 1'b0;
            r_d.hi_ok = 1'b0;
        end else if (bus_start) begin
            r_d.st  = ST_ADDR1;
            r_d.cnt = '0;
            r_d.drv = 1'b0;
            r_d.sel = 1'b0;
            r_d.rd  = 1'b0;
            r_d.gc  = 1'b0;
        end else if (r_q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (r_q.cnt < LAST_CNT) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.st == ST_TX) r_d.sh = {r_q.sh[DATA_BITS-2:0], 1'b1};
                    else                 r_d.sh = {r_q.sh[DATA_BITS-2:0], sda_s};
                end else if (r_q.cnt == ACK_CNT && r_q.st == ST_TX) begin
                    r_d.nack = sda_s;
                end
            end else if (scl_fall) begin
                if (r_q.cnt < LAST_CNT) begin
                    if (r_q.st == ST_TX) r_d.drv = ~r_q.sh[DATA_BITS-1];
                end else if (r_q.cnt == LAST_CNT) begin
                    r_d.cnt = ACK_CNT;
                    r_d.drv = 1'b0;
                    r_d.nx  = ST_IDLE;
                    unique case (r_q.st)
                        ST_ADDR1: begin
                            if (gc_hit) begin
                                r_d.drv = 1'b1; r_d.sel = 1'b1; r_d.gc = 1'b1;
                                r_d.rd  = 1'b0; r_d.nx  = ST_RX;
                            end else if (!mode10_i && hit7) begin
                                r_d.drv = 1'b1; r_d.sel = 1'b1; r_d.rd = r_q.sh[0];
                                r_d.nx  = r_q.sh[0] ? ST_TX : ST_RX;
                            end else if (mode10_i && pfx_hit && !r_q.sh[0]) begin
                                r_d.drv = 1'b1; r_d.nx = ST_ADDR2;
                            end else if (mode10_i && pfx_hit && r_q.hi_ok) begin
                                r_d.drv = 1'b1; r_d.sel = 1'b1; r_d.rd = 1'b1;
                                r_d.nx  = ST_TX;
                            end
                        end
                        ST_ADDR2: begin
                            if (lo_hit) begin
                                r_d.drv = 1'b1; r_d.sel = 1'b1; r_d.hi_ok = 1'b1;
                                r_d.nx  = ST_RX;
                            end else begin
                                r_d.hi_ok = 1'b0;
                            end
                        end
                        ST_RX: begin
                            r_d.drv = 1'b1; r_d.nx = ST_RX;
                            r_d.rx  = r_q.sh; r_d.rxv = 1'b1;
                        end
                        ST_TX: begin
                            r_d.nx = ST_TX;
                        end
                        default: ;
                    endcase
                    if (r_d.nx == ST_IDLE) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end
                end else begin
                    r_d.cnt = '0;
                    r_d.drv = 1'b0;
                    if (r_q.st == ST_TX && r_q.nack) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.st = r_q.nx;
                        if (r_q.nx == ST_TX) begin
                            r_d.sh   = tx_byte_i;
                            r_d.drv  = ~tx_byte_i[DATA_BITS-1];
                            r_d.nack = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REG_RST;
        else        r_q <= r_d;
    end

    assign sda_pull_o = r_q.drv;
    assign rx_data_o  = r_q.rx;
    assign rx_valid_o = r_q.rxv;
    assign selected_o = r_q.sel;
    assign dir_read_o = r_q.rd;
    assign gcall_o    = r_q.gc;

    // R7
    pull_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.drv) |-> ($past(scl_fall) || ($past(bus_start || bus_stop) && !r_q.drv)));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_stop) |-> (!selected_o && !sda_pull_o));

    // R8
    rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R9
    rxv_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (selected_o && !dir_read_o));

    // R4
    gcall_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gcall_o |-> (selected_o && !dir_read_o));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_start) |-> (!selected_o && !sda_pull_o));

endmodule

// File: tb/sim_i2c_tgt_addr_dec.sv
module sim_i2c_tgt_addr_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       mode10 = 1'b0;
    logic [9:0] own = 10'h05A;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_pull, rx_valid, selected, dir_read, gcall;
    logic [7:0] rx_data;
    logic       sda_line;

    int checks = 0, fails = 0, rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    bit done = 1'b0;
    localparam int Q = 5;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_tgt_addr_dec u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .mode10_i(mode10), .own_addr_i(own), .tx_byte_i(tx_byte),
        .sda_pull_o(sda_pull), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .selected_o(selected), .dir_read_o(dir_read), .gcall_o(gcall)
    );

    always @(negedge clk) if (rx_valid) begin rx_cnt++; rx_last = rx_data; end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit want_release, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q); scl_m = 1'b0; tick(Q);
        if (want_release) chk(sda_pull == 1'b0, "R7 release after ack", sda_pull, 0);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
            v[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
        end
        send_bit(nack);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a1, a2;
        logic [7:0] v, d, lo;
        int r0;
        tick(4); rst_n = 1'b1; tick(4);
        // R7 R9 reset state
        chk(sda_pull == 0, "R7 reset pull", sda_pull, 0);
        chk(selected == 0, "R9 reset sel", selected, 0);
        chk(rx_valid == 0, "R8 reset valid", rx_valid, 0);

        // R3 R4 R8 R9 R2 R1: 7-bit sweep of every address with a write
        for (int a = 0; a < 128; a++) begin
            bit expm;
            expm = (a == 'h5A) || (a == 0);
            bus_start();
            wr_byte({a[6:0], 1'b0}, 1'b1, a1);
            chk(a1 == expm, (a == 0) ? "R4 gcall ack" : "R3 addr ack", a1, expm);
            chk(selected == expm, "R3 selected", selected, expm);
            if (a == 0) chk(gcall == 1, "R4 gcall flag", gcall, 1);
            d = 8'(a) ^ 8'hC3;
            r0 = rx_cnt;
            wr_byte(d, 1'b1, a2);
            chk(a2 == expm, expm ? "R8 data ack" : "R9 no data ack", a2, expm);
            chk((rx_cnt - r0) == (expm ? 1 : 0), expm ? "R8 one strobe" : "R9 no strobe",
                rx_cnt - r0, expm ? 1 : 0);
            if (expm) chk(rx_last == d, "R2 msb-first byte", rx_last, d);
            bus_stop(); tick(2);
            chk(selected == 0, "R1 stop deselects", selected, 0);
        end

        // R11 read in 7-bit mode
        tx_byte = 8'hA5;
        bus_start();
        wr_byte({7'h5A, 1'b1}, 1'b0, a1);
        chk(a1 == 1, "R3 read ack", a1, 1);
        chk(dir_read == 1, "R3 direction", dir_read, 1);
        tx_byte = 8'h3C;
        rd_byte(1'b0, v);
        chk(v == 8'hA5, "R11 first byte", v, 8'hA5);
        rd_byte(1'b1, v);
        chk(v == 8'h3C, "R11 reload byte", v, 8'h3C);
        tick(Q);
        chk(sda_pull == 0, "R11 release on nack", sda_pull, 0);
        bus_stop(); tick(2);

        // R10 repeated start in 7-bit mode
        bus_start();
        wr_byte({7'h11, 1'b0}, 1'b1, a1);
        chk(a1 == 0, "R9 wrong addr", a1, 0);
        bus_start();
        wr_byte({7'h5A, 1'b0}, 1'b1, a1);
        chk(a1 == 1, "R10 reselect", a1, 1);
        r0 = rx_cnt;
        wr_byte(8'h7E, 1'b1, a2);
        chk(rx_cnt - r0 == 1 && rx_last == 8'h7E, "R10 data after Sr", rx_last, 8'h7E);
        bus_start();
        wr_byte({7'h22, 1'b0}, 1'b1, a1);
        chk(a1 == 0 && selected == 0, "R10 deselect", selected, 0);
        bus_stop(); tick(2);

        // R1 STOP in the middle of a data byte
        bus_start();
        wr_byte({7'h5A, 1'b0}, 1'b1, a1);
        r0 = rx_cnt;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop(); tick(2);
        chk(selected == 0 && sda_pull == 0, "R1 abort by stop", selected, 0);
        chk(rx_cnt == r0, "R1 no partial byte", rx_cnt - r0, 0);

        // R5 10-bit sweep: all upper pairs, a spread of lower bytes
        mode10 = 1'b1; own = 10'h2B6;
        for (int hi = 0; hi < 4; hi++) begin
            for (int k = 0; k < 20; k++) begin
                if (k < 8)       lo = 8'hB6 ^ 8'(1 << k);
                else if (k == 8) lo = 8'hB6;
                else             lo = 8'(k * 29);
                bus_start();
                wr_byte({5'b11110, hi[1:0], 1'b0}, 1'b1, a1);
                chk(a1 == (hi == 2), "R5 prefix ack", a1, hi == 2);
                if (a1) begin
                    wr_byte(lo, 1'b1, a2);
                    chk(a2 == (lo == 8'hB6), "R5 low byte ack", a2, lo == 8'hB6);
                    chk(selected == (lo == 8'hB6), "R5 selected", selected, lo == 8'hB6);
                end else begin
                    chk(selected == 0, "R5 no select", selected, 0);
                end
                bus_stop(); tick(2);
            end
        end

        // R4 broadcast in 10-bit mode
        bus_start();
        wr_byte(8'h00, 1'b1, a1);
        chk(a1 == 1 && gcall == 1, "R4 gcall 10-bit", gcall, 1);
        bus_stop(); tick(2);

        // R6 R10 10-bit read after repeated start
        bus_start();
        wr_byte(8'hF4, 1'b1, a1);
        wr_byte(8'hB6, 1'b1, a2);
        chk(a1 && a2, "R5 full match", a2, 1);
        tx_byte = 8'h96;
        bus_start();
        wr_byte(8'hF5, 1'b0, a1);
        chk(a1 == 1 && dir_read == 1, "R6 read resume", dir_read, 1);
        rd_byte(1'b1, v);
        chk(v == 8'h96, "R11 10-bit read data", v, 8'h96);
        bus_stop(); tick(2);
        bus_start();
        wr_byte(8'hF5, 1'b1, a1);
        chk(a1 == 0 && selected == 0, "R6 no resume after stop", a1, 0);
        bus_stop(); tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule